// File: doc/BRIEF.md
# PCI Bridge Window Address Decoder

This block decides, for a PCI-to-PCI bridge, whether a memory or I/O transaction should be claimed and passed to the other side. It holds two memory windows and one I/O window, each set by a base and a limit. It also holds a control word with three parts: an ISA-compatibility enable, a VGA enable, and a set of private-region enables that apply to the downstream side.

Every request carries an address, a space flag (memory or I/O), and a side flag. The side flag tells whether the request arrived on the upstream (primary) interface or the downstream (secondary) interface. A request arriving upstream is claimed when it falls in the set of addresses routed downstream. A request arriving downstream is claimed when it falls outside that set. Two conditions stop a downstream request from being claimed: the request comes from an internal translation or DMA agent, or it hits an enabled private region.

A one-cycle register stage holds the decision. The registers are loaded through a simple write port.

Top module: `pci_bridge_window_decoder`

## Requirements
- R1: After reset, each window has base all ones and limit zero, so all windows are disabled. The ISA, VGA and private enables are clear and `dec_valid` is low. With this state, no upstream request is claimed, and every downstream request is claimed unless it is flagged as internal.
- R2: Memory windows work in 1 MB units. A base written as B covers addresses from {B[31:20],20'h00000} up to {L[31:20],20'hFFFFF}, where L is the limit. Both ends are inclusive.
- R3: When a window's stored base is greater than its stored limit, that window matches no address.
- R4: The I/O window works in 4 KB units inside a 16-bit I/O space. It covers {B[15:12],12'h000} to {L[15:12],12'hFFF}. An I/O address with any bit set in [31:16] is never inside the window. Memory windows apply only to memory requests, and the I/O window applies only to I/O requests.
- R5: Upstream decoding is positive. A request with `req_from_sec`=0 is claimed exactly when its address is in the downstream set. The downstream set is made of the windows that match the request's space, together with the ISA and VGA adjustments.
- R6: Downstream decoding is inverse. A request with `req_from_sec`=1 is claimed exactly when its address is not in the downstream set, subject to R9 and R10.
- R7: ISA mode is control bit 0. When it is set, an I/O address below 64 KB with bits [9:8] not equal to 00 is removed from the downstream set, even when it lies inside the I/O window. Such an address is therefore claimed upstream-bound from the secondary side.
- R8: VGA mode is control bit 1. When it is set, these addresses are added to the downstream set regardless of the windows and of ISA mode:
  - memory addresses from 0xA0000 to 0xBFFFF;
  - I/O addresses whose bits [9:0] fall in 0x3B0–0x3BB or 0x3C0–0x3DF.
- R9: The private enables are control bits [7:4]. Bit 4+k marks the 16 MB memory region 0x8000_0000 + k·0x0100_0000 as private. A downstream memory request that hits an enabled region is never claimed. This rule takes priority over every other downstream rule, and it has no effect on upstream requests.
- R10: A downstream request with `req_internal_src`=1 is never claimed.
- R11: `dec_valid` is high in the cycle after `req_valid` was high and low otherwise. `dec_claim` is low whenever `dec_valid` is low. The decision uses the register contents as they stood in the request's cycle.
- R12: The write port register map is: 0 = memory window 0 base, 1 = its limit, 2 = memory window 1 base, 3 = its limit, 4 = I/O base, 5 = I/O limit, 6 = control. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (R12) |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_from_sec | input | 1 | 1 = seen on downstream side, 0 = upstream side |
| req_internal_src | input | 1 | Request issued by an internal translation or DMA agent |
| dec_valid | output | 1 | Decision present |
| dec_claim | output | 1 | Claim and forward across the bridge |

## Verification
The assertions check the decision timing and the rules that can only ever refuse a claim, on every cycle. Those rules are:
- an internal source is never claimed downstream;
- an enabled private region is never claimed downstream;
- an address excluded by ISA mode is never claimed upstream;
- no claim is made when both memory windows are disabled.

The window boundaries, the 1 MB and 4 KB rounding, the inversion between the two sides and the VGA ranges are positive claims that depend on the programmed values. Only the bench's scenarios show them: it probes each edge of each programmed window and each VGA range.

// File: rtl/pci_bridge_window_decoder.sv
module pci_bridge_window_decoder #(
  parameter int ADDR_W   = 32,
  parameter int MEM_GRAN = 20,
  parameter int IO_W     = 16,
  parameter int IO_GRAN  = 12,
  parameter int PRIV_N   = 4,
  parameter int PRIV_LOG = 24,
  parameter logic [ADDR_W-1:0] PRIV_BASE = 'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_from_sec,
  input  logic              req_internal_src,
  output logic              dec_valid,
  output logic              dec_claim
);
  localparam int MW  = ADDR_W - MEM_GRAN;
  localparam int IOR = IO_W - IO_GRAN;
  localparam int PIW = $clog2(PRIV_N);
  localparam int PTW = ADDR_W - PRIV_LOG - PIW;
  localparam logic [PTW-1:0]    PRIV_TAG = PRIV_BASE[ADDR_W-1:PRIV_LOG+PIW];
  localparam logic [ADDR_W-1:0] VGA_LO   = 'hA0000;
  localparam logic [ADDR_W-1:0] VGA_HI   = 'hBFFFF;

  logic [MW-1:0]     mem0_base, mem0_limit, mem1_base, mem1_limit;
  logic [IOR-1:0]    io_base, io_limit;
  logic              isa_en, vga_en;
  logic [PRIV_N-1:0] priv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem0_base  <= '1;
      mem0_limit <= '0;
      mem1_base  <= '1;
      mem1_limit <= '0;
      io_base    <= '1;
      io_limit   <= '0;
      isa_en     <= 1'b0;
      vga_en     <= 1'b0;
      priv_en    <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: mem0_base  <= cfg_wdata[ADDR_W-1:MEM_GRAN];
        3'd1: mem0_limit <= cfg_wdata[ADDR_W-1:MEM_GRAN];
        3'd2: mem1_base  <= cfg_wdata[ADDR_W-1:MEM_GRAN];
        3'd3: mem1_limit <= cfg_wdata[ADDR_W-1:MEM_GRAN];
        3'd4: io_base    <= cfg_wdata[IO_W-1:IO_GRAN];
        3'd5: io_limit   <= cfg_wdata[IO_W-1:IO_GRAN];
        3'd6: begin
          isa_en  <= cfg_wdata[0];
          vga_en  <= cfg_wdata[1];
          priv_en <= cfg_wdata[4 +: PRIV_N];
        end
        default: ;
      endcase
    end
  end

  wire [MW-1:0]  a_mem = req_addr[ADDR_W-1:MEM_GRAN];
  wire [IOR-1:0] a_io  = req_addr[IO_W-1:IO_GRAN];
  wire [9:0]     a10   = req_addr[9:0];

  wire in_mem0 = (mem0_base <= mem0_limit) && (a_mem >= mem0_base) && (a_mem <= mem0_limit);
  wire in_mem1 = (mem1_base <= mem1_limit) && (a_mem >= mem1_base) && (a_mem <= mem1_limit);

  wire io_space = (req_addr[ADDR_W-1:IO_W] == '0);
  wire in_io    = io_space && (io_base <= io_limit) && (a_io >= io_base) && (a_io <= io_limit);

  wire isa_block = isa_en && io_space && (req_addr[9:8] != 2'b00);

  wire vga_mem = vga_en && (req_addr >= VGA_LO) && (req_addr <= VGA_HI);
  wire vga_io  = vga_en && (((a10 >= 10'h3B0) && (a10 <= 10'h3BB)) ||
                            ((a10 >= 10'h3C0) && (a10 <= 10'h3DF)));

  wire down_set = req_is_io ? ((in_io && !isa_block) || vga_io)
                            : (in_mem0 || in_mem1 || vga_mem);

  wire [PIW-1:0] priv_idx = req_addr[PRIV_LOG +: PIW];
  wire priv_hit = !req_is_io && (req_addr[ADDR_W-1:PRIV_LOG+PIW] == PRIV_TAG) && priv_en[priv_idx];

  wire claim_next = req_from_sec ? (!down_set && !priv_hit && !req_internal_src) : down_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_claim <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_claim <= req_valid && claim_next;
    end
  end
endmodule

// File: rtl/pci_bridge_window_decoder_chk.sv
module pci_bridge_window_decoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int MEM_GRAN = 20,
  parameter int IO_W     = 16,
  parameter int IO_GRAN  = 12,
  parameter int PRIV_N   = 4,
  parameter int PRIV_LOG = 24,
  parameter logic [ADDR_W-1:0] PRIV_BASE = 'h8000_0000
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       req_is_io,
  input logic                       req_from_sec,
  input logic                       req_internal_src,
  input logic                       dec_valid,
  input logic                       dec_claim,
  input logic [ADDR_W-MEM_GRAN-1:0] mem0_base,
  input logic [ADDR_W-MEM_GRAN-1:0] mem0_limit,
  input logic [ADDR_W-MEM_GRAN-1:0] mem1_base,
  input logic [ADDR_W-MEM_GRAN-1:0] mem1_limit,
  input logic                       isa_en,
  input logic                       vga_en,
  input logic [PRIV_N-1:0]          priv_en
);
  localparam int PIW = $clog2(PRIV_N);
  wire [ADDR_W-1:0] priv_off = req_addr - PRIV_BASE;
  wire in_priv_span = (req_addr >= PRIV_BASE) && (priv_off < (ADDR_W'(PRIV_N) << PRIV_LOG));
  wire [PIW-1:0] region = priv_off[PRIV_LOG +: PIW];

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid);
  assert_no_claim_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_claim);
  assert_internal_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_from_sec && req_internal_src) |=> !dec_claim);
  assert_private_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_from_sec && !req_is_io && in_priv_span && priv_en[region]) |=> !dec_claim);
  assert_isa_excluded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_from_sec && req_is_io && isa_en && !vga_en &&
     (req_addr < (ADDR_W'(1) << IO_W)) && (req_addr[9:8] != 2'b00)) |=> !dec_claim);
  assert_disabled_windows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_from_sec && !req_is_io && !vga_en &&
     (mem0_base > mem0_limit) && (mem1_base > mem1_limit)) |=> !dec_claim);
endmodule

bind pci_bridge_window_decoder pci_bridge_window_decoder_chk #(
  .ADDR_W(ADDR_W), .MEM_GRAN(MEM_GRAN), .IO_W(IO_W), .IO_GRAN(IO_GRAN),
  .PRIV_N(PRIV_N), .PRIV_LOG(PRIV_LOG), .PRIV_BASE(PRIV_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_is_io(req_is_io), .req_from_sec(req_from_sec), .req_internal_src(req_internal_src),
  .dec_valid(dec_valid), .dec_claim(dec_claim),
  .mem0_base(mem0_base), .mem0_limit(mem0_limit), .mem1_base(mem1_base), .mem1_limit(mem1_limit),
  .isa_en(isa_en), .vga_en(vga_en), .priv_en(priv_en)
);

// File: tb/pci_bridge_window_decoder_tb.sv
module pci_bridge_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_is_io = 1'b0;
  logic        req_from_sec = 1'b0;
  logic        req_internal_src = 1'b0;
  logic        dec_valid, dec_claim;

  int checks = 0;
  int fails = 0;
  bit    exp_q[$];
  string tag_q[$];

  logic [31:0] s_m0b = '1, s_m0l = '0, s_m1b = '1, s_m1l = '0;
  logic [15:0] s_iob = '1, s_iol = '0;
  logic [7:0]  s_ctl = '0;

  always #5 clk = ~clk;

  pci_bridge_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_is_io(req_is_io),
    .req_from_sec(req_from_sec), .req_internal_src(req_internal_src),
    .dec_valid(dec_valid), .dec_claim(dec_claim)
  );

  function automatic bit in_mem(logic [31:0] b, logic [31:0] l, logic [31:0] a);
    return (b[31:20] <= l[31:20]) && (a >= {b[31:20], 20'h0}) && (a <= {l[31:20], 20'hFFFFF});
  endfunction

  function automatic bit model(logic [31:0] a, bit io, bit sec, bit internal);
    bit dn, priv;
    bit io_low = (a[31:16] == 16'h0);
    bit in_io = io_low && (s_iob[15:12] <= s_iol[15:12]) &&
                (a[15:0] >= {s_iob[15:12], 12'h0}) && (a[15:0] <= {s_iol[15:12], 12'hFFF});
    bit isa = s_ctl[0] && io_low && (a[9:8] != 2'b00);
    bit vm = s_ctl[1] && (a >= 32'hA0000) && (a <= 32'hBFFFF);
    bit vi = s_ctl[1] && (((a[9:0] >= 10'h3B0) && (a[9:0] <= 10'h3BB)) ||
                          ((a[9:0] >= 10'h3C0) && (a[9:0] <= 10'h3DF)));
    dn = io ? ((in_io && !isa) || vi) : (in_mem(s_m0b, s_m0l, a) || in_mem(s_m1b, s_m1l, a) || vm);
    priv = !io && (a >= 32'h8000_0000) && (a < 32'h8400_0000) && s_ctl[4 + a[25:24]];
    return sec ? (!dn && !priv && !internal) : dn;
  endfunction

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    case (idx)
      3'd0: s_m0b = d;
      3'd1: s_m0l = d;
      3'd2: s_m1b = d;
      3'd3: s_m1l = d;
      3'd4: s_iob = d[15:0];
      3'd5: s_iol = d[15:0];
      default: s_ctl = d[7:0];
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input bit io, input bit sec, input bit internal, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_from_sec = sec; req_internal_src = internal;
    exp_q.push_back(model(a, io, sec, internal));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      bit e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: dec_valid with no request pending (actual 1 expected 0)");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dec_claim !== e) begin
          fails++;
          $display("FAIL %s: addr=%h actual claim=%b expected=%b", t, req_addr, dec_claim, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0 || dec_claim !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs actual %b%b expected 00", dec_valid, dec_claim);
    end
    rst_n = 1'b1;
    issue(32'h1000_0000, 0, 0, 0, "R1 upstream after reset");
    issue(32'h1000_0000, 0, 1, 0, "R1 downstream after reset");
    issue(32'h0000_2000, 1, 1, 0, "R1 io downstream after reset");

    cfg_write(3'd0, 32'h1000_0000);
    cfg_write(3'd1, 32'h1FF0_0000);
    cfg_write(3'd2, 32'h4000_0000);
    cfg_write(3'd3, 32'h4000_0000);
    cfg_write(3'd4, 32'h0000_2000);
    cfg_write(3'd5, 32'h0000_3000);

    issue(32'h1000_0000, 0, 0, 0, "R2 R5 mem0 low edge");
    issue(32'h0FFF_FFFF, 0, 0, 0, "R2 below mem0");
    issue(32'h1FFF_FFFF, 0, 0, 0, "R2 mem0 high edge");
    issue(32'h2000_0000, 0, 0, 0, "R2 above mem0");
    issue(32'h400F_FFFF, 0, 0, 0, "R2 mem1 single MB top");
    issue(32'h4010_0000, 0, 0, 0, "R2 above mem1");
    issue(32'h0000_2000, 1, 0, 0, "R4 io low edge");
    issue(32'h0000_1FFF, 1, 0, 0, "R4 below io");
    issue(32'h0000_3FFF, 1, 0, 0, "R4 io high edge");
    issue(32'h0000_4000, 1, 0, 0, "R4 above io");
    issue(32'h0001_2000, 1, 0, 0, "R4 io upper bits set");
    issue(32'h0000_2000, 0, 0, 0, "R4 memory request at io address");
    issue(32'h1000_0000, 1, 0, 0, "R4 io request at memory address");

    issue(32'h1000_0000, 0, 1, 0, "R6 downstream inside mem0");
    issue(32'h5000_0000, 0, 1, 0, "R6 downstream outside windows");
    issue(32'h0000_1FFF, 1, 1, 0, "R6 downstream io outside");
    issue(32'h0000_2500, 1, 1, 0, "R6 downstream io inside");
    issue(32'h5000_0000, 0, 1, 1, "R10 internal source");
    issue(32'h0000_1FFF, 1, 1, 1, "R10 internal source io");
    issue(32'h5000_0000, 0, 0, 1, "R10 flag ignored upstream");

    cfg_write(3'd6, 32'h0000_0020);
    issue(32'h8100_0010, 0, 1, 0, "R9 private region 1");
    issue(32'h8000_0010, 0, 1, 0, "R9 region 0 not enabled");
    issue(32'h81FF_FFFF, 0, 1, 0, "R9 private top");
    issue(32'h8200_0000, 0, 1, 0, "R9 past private region");
    issue(32'h8100_0010, 1, 1, 0, "R9 io unaffected");
    cfg_write(3'd2, 32'h8100_0000);
    cfg_write(3'd3, 32'h8100_0000);
    issue(32'h8100_0010, 0, 0, 0, "R9 upstream unaffected");
    issue(32'h8100_0010, 0, 1, 0, "R9 priority over window");

    cfg_write(3'd6, 32'h0000_0001);
    issue(32'h0000_2000, 1, 0, 0, "R7 isa low quarter");
    issue(32'h0000_20FF, 1, 0, 0, "R7 isa quarter top");
    issue(32'h0000_2100, 1, 0, 0, "R7 isa excluded 01");
    issue(32'h0000_2300, 1, 0, 0, "R7 isa excluded 11");
    issue(32'h0000_2100, 1, 1, 0, "R7 isa excluded goes upstream");
    issue(32'h1000_0100, 0, 0, 0, "R7 memory unaffected");

    cfg_write(3'd6, 32'h0000_0003);
    issue(32'h000A_0000, 0, 0, 0, "R8 vga mem low");
    issue(32'h000B_FFFF, 0, 0, 0, "R8 vga mem high");
    issue(32'h0009_FFFF, 0, 0, 0, "R8 below vga mem");
    issue(32'h000C_0000, 0, 0, 0, "R8 above vga mem");
    issue(32'h0000_03B0, 1, 0, 0, "R8 vga io mono low");
    issue(32'h0000_03BB, 1, 0, 0, "R8 vga io mono high");
    issue(32'h0000_03BC, 1, 0, 0, "R8 vga io gap");
    issue(32'h0000_03C0, 1, 0, 0, "R8 vga io over isa");
    issue(32'h0000_03DF, 1, 0, 0, "R8 vga io colour high");
    issue(32'h0000_13C4, 1, 0, 0, "R8 vga io alias");
    issue(32'h0000_03E0, 1, 0, 0, "R8 above vga io");
    issue(32'h000A_0000, 0, 1, 0, "R8 vga mem downstream");

    cfg_write(3'd0, 32'h2000_0000);
    cfg_write(3'd6, 32'h0000_0000);
    issue(32'h1800_0000, 0, 0, 0, "R3 base above limit");
    issue(32'h2000_0000, 0, 0, 0, "R3 at disabled base");
    issue(32'h1800_0000, 0, 1, 0, "R3 disabled downstream");

    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h1000_0000; req_is_io = 1'b0; req_from_sec = 1'b0;
    exp_q.push_back(1'b0); tag_q.push_back("R12 decision uses old registers");
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h1000_0000; s_m0b = 32'h1000_0000;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    issue(32'h1000_0000, 0, 0, 0, "R12 write visible next cycle");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d decisions missing (expected 0)", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule